// File: doc/BRIEF.md
# Serial Codec Frame Transmitter (Master Mode)

This block is the transmit half of a serial codec link in which the chip owns the clocks. It divides the core clock down to a bit clock and marks the start of every frame with an active-high frame-sync pulse. Within each frame it shifts a fixed number of fixed-width words out least significant bit first. The frame may be longer than the words it carries. The bit periods that remain after the last word are driven low until the next frame begins.

Words come from a small transmit FIFO through a valid/ready write port. A word is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops while the FIFO is full, and the writer must then hold `wr_valid` and `wr_data` until the word is taken. A refill interrupt is raised while the FIFO has drained to the alarm level or below. Separate one-cycle start and stop pulses control the transmitter, and it is stopped while its setup is changed. When a word slot begins and no word is queued, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `codec_frame_tx`

## Requirements
- R1: After reset, `bclk`, `fsync`, `sdata` and `underrun` are low, `wr_ready` is high and the FIFO is empty.
- R2: While running, `bclk` has a period of CLK_DIV core clocks. It is high for the first CLK_DIV/2 of them, and the bit period starts at its rising edge.
- R3: A frame is FRAME_BITS bit periods long. `fsync` is high for exactly the first bit period of each frame and low for the rest.
- R4: Word k of a frame (k from 0) fills bit periods k*WORD_W to k*WORD_W+WORD_W-1, least significant bit first. The first bit goes out in the period where `fsync` is high, and the words come in FIFO order.
- R5: Every bit period from WORDS_PER_FRAME*WORD_W up to the end of the frame drives `sdata` low.
- R6: `sdata` and `fsync` change only on the core clock edge that raises `bclk`, so a receiver can capture them on the falling edge of `bclk`.
- R7: A word is stored when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while FIFO_DEPTH words are held, and a word offered then is not stored and never transmitted.
- R8: A word slot that begins with the FIFO empty is sent as all zeros and sets `underrun`. The flag stays set until the next accepted start pulse.
- R9: `irq` is high exactly when `irq_en` is high and the FIFO holds ALARM_WORDS words or fewer.
- R10: After a `tx_disable` pulse, `bclk`, `fsync` and `sdata` are low from the next core clock edge onward. They stay low until a `tx_enable` pulse starts a new frame, and queued words are kept.
- R11: A `tx_enable` pulse while the transmitter is running has no effect, and the frame timing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core (master) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | One-cycle start pulse |
| tx_disable | input | 1 | One-cycle stop pulse; takes priority over start |
| irq_en | input | 1 | Enables the refill interrupt |
| wr_valid | input | 1 | Write port: word offered |
| wr_ready | output | 1 | Write port: FIFO can take a word |
| wr_data | input | WORD_W | Write port: word to transmit |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync, active high |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a slot found the FIFO empty |
| irq | output | 1 | Refill interrupt |

## Verification
The bench builds the block with a divide of 4, a 52-bit frame carrying three 16-bit words, a 16-word FIFO and an alarm level of 8 words. The frame length is not a multiple of the word width, so four padding bits follow the payload, and the bench checks them in every captured frame. A 16-word FIFO fills within a few cycles while the transmitter is stopped, which exposes the full condition, the refused extra word and the crossing of the alarm level. Five full frames plus one partly empty frame drain the FIFO and show the underrun behaviour.

// File: rtl/codec_tx_pkg.sv
package codec_tx_pkg;
  // Where the sequencer sits inside a frame.
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_WORD = 2'd1,
    SEG_PAD  = 2'd2
  } seg_e;

  function automatic bit frame_fits(int frame_bits, int word_w, int words);
    return (word_w * words) <= frame_bits;
  endfunction
endpackage

// File: rtl/codec_tx_fifo.sv
module codec_tx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  output logic                         push_ready,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign push_ready = (cnt_q != FULL);
  assign empty      = (cnt_q == '0);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;
  assign head       = mem[rd_q];
  assign level      = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CW'(1))
             || (cnt_q + CW'(1) == $past(cnt_q)));
endmodule

// File: rtl/codec_tx_bclk.sv
module codec_tx_bclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o,
  output logic go_o,
  output logic tick_o,
  output logic bclk_o
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST   = CW'(DIV-1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  generate
    if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("codec_tx_bclk: DIV must be even and at least 2");
    end
  endgenerate

  logic [CW-1:0] cnt_q, cnt_n;
  logic          run_q, bclk_q;

  assign tick_o = run_q && !stop_i && (cnt_q == LAST);
  assign go_o   = start_i && !stop_i && !run_q;
  assign cnt_n  = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  assign run_o  = run_q;
  assign bclk_o = bclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (go_o) begin
      run_q  <= 1'b1;
      cnt_q  <= LAST;
      bclk_q <= 1'b0;
    end else if (run_q) begin
      cnt_q  <= cnt_n;
      bclk_q <= (cnt_n < HALF_C);
    end
  end

  p_stopped_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !bclk_q);

  generate
    if (HALF >= 2) begin : g_high_chk
      p_bclk_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && $rose(bclk_q) |=> bclk_q || !run_q);
    end
  endgenerate
endmodule

// File: rtl/codec_tx_seq.sv
module codec_tx_seq
  import codec_tx_pkg::*;
#(
  parameter int FRAME = 52,
  parameter int WW    = 16,
  parameter int NW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          go_i,
  input  logic          stop_i,
  input  logic          tick_i,
  input  logic          bclk_i,
  input  logic          empty_i,
  input  logic [WW-1:0] head_i,
  output logic          pop_o,
  output logic          fsync_o,
  output logic          sdata_o,
  output logic          underrun_o
);
  localparam int PW = $clog2(FRAME);
  localparam int BW = $clog2(WW);
  localparam int IW = $clog2(NW+1);
  localparam logic [PW-1:0] P_LAST = PW'(FRAME-1);
  localparam logic [BW-1:0] B_LAST = BW'(WW-1);
  localparam logic [IW-1:0] N_WORDS = IW'(NW);

  logic [PW-1:0] pos_q, pos_n;
  logic [BW-1:0] wbit_q, wbit_n;
  logic [IW-1:0] widx_q, widx_n;
  logic [WW-1:0] sh_q;
  logic          fs_q, sd_q, ur_q;
  logic          wrap, slot_start;
  seg_e          seg_n;

  always_comb begin
    wrap   = (pos_q == P_LAST);
    pos_n  = pos_q + PW'(1);
    wbit_n = wbit_q;
    widx_n = widx_q;
    slot_start = 1'b0;
    if (wrap) begin
      pos_n  = '0;
      wbit_n = '0;
      widx_n = '0;
      slot_start = (NW > 0);
    end else if (widx_q < N_WORDS) begin
      if (wbit_q == B_LAST) begin
        wbit_n = '0;
        widx_n = widx_q + IW'(1);
        slot_start = (widx_q + IW'(1) < N_WORDS);
      end else begin
        wbit_n = wbit_q + BW'(1);
      end
    end
    if (!run_i)                seg_n = SEG_IDLE;
    else if (widx_n < N_WORDS) seg_n = SEG_WORD;
    else                       seg_n = SEG_PAD;
  end

  assign pop_o      = tick_i && slot_start && !empty_i;
  assign fsync_o    = fs_q;
  assign sdata_o    = sd_q;
  assign underrun_o = ur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      wbit_q <= '0;
      widx_q <= N_WORDS;
      sh_q   <= '0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else if (go_i) begin
      pos_q  <= P_LAST;
      wbit_q <= '0;
      widx_q <= N_WORDS;
      sh_q   <= '0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
      ur_q   <= 1'b0;
    end else if (!run_i || stop_i) begin
      fs_q <= 1'b0;
      sd_q <= 1'b0;
      sh_q <= '0;
    end else if (tick_i) begin
      pos_q  <= pos_n;
      wbit_q <= wbit_n;
      widx_q <= widx_n;
      fs_q   <= wrap;
      if (slot_start) begin
        if (!empty_i) begin
          sd_q <= head_i[0];
          sh_q <= head_i >> 1;
        end else begin
          sd_q <= 1'b0;
          sh_q <= '0;
          ur_q <= 1'b1;
        end
      end else if (seg_n == SEG_WORD) begin
        sd_q <= sh_q[0];
        sh_q <= sh_q >> 1;
      end else begin
        sd_q <= 1'b0;
      end
    end
  end

  p_edge_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !stop_i && $past(run_i) && !$rose(bclk_i)
    |-> $stable(sd_q) && $stable(fs_q));
  p_fsync_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (pos_q == '0));
  p_pad_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (widx_q >= N_WORDS) |-> !sd_q);
  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ur_q && !go_i |=> ur_q);
endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx
  import codec_tx_pkg::*;
#(
  parameter int CLK_DIV         = 4,
  parameter int FRAME_BITS      = 52,
  parameter int WORD_W          = 16,
  parameter int WORDS_PER_FRAME = 3,
  parameter int FIFO_DEPTH      = 16,
  parameter int ALARM_WORDS     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              tx_disable,
  input  logic              irq_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              bclk,
  output logic              fsync,
  output logic              sdata,
  output logic              underrun,
  output logic              irq
);
  localparam int LW = $clog2(FIFO_DEPTH+1);
  localparam logic [LW-1:0] ALARM_C = LW'(ALARM_WORDS);

  generate
    if (!frame_fits(FRAME_BITS, WORD_W, WORDS_PER_FRAME)) begin : g_bad_frame
      $error("codec_frame_tx: words do not fit in the frame");
    end
    if (ALARM_WORDS > FIFO_DEPTH || FIFO_DEPTH < 2 || WORD_W < 2) begin : g_bad_cfg
      $error("codec_frame_tx: inconsistent FIFO or word parameters");
    end
  endgenerate

  logic              run, go, tick, pop, empty;
  logic [WORD_W-1:0] head;
  logic [LW-1:0]     level;

  codec_tx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(wr_valid), .push_ready(wr_ready), .push_data(wr_data),
    .pop(pop), .head(head), .empty(empty), .level(level)
  );

  codec_tx_bclk #(.DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_n),
    .start_i(tx_enable), .stop_i(tx_disable),
    .run_o(run), .go_o(go), .tick_o(tick), .bclk_o(bclk)
  );

  codec_tx_seq #(.FRAME(FRAME_BITS), .WW(WORD_W), .NW(WORDS_PER_FRAME)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .run_i(run), .go_i(go), .stop_i(tx_disable), .tick_i(tick), .bclk_i(bclk),
    .empty_i(empty), .head_i(head),
    .pop_o(pop), .fsync_o(fsync), .sdata_o(sdata), .underrun_o(underrun)
  );

  assign irq = irq_en && (level <= ALARM_C);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en && wr_ready);
endmodule

// File: tb/codec_frame_tx_test.sv
module codec_frame_tx_test;
  localparam int FB = 52;
  localparam int WW = 16;

  logic clk = 1'b0;
  logic rst_n, tx_enable, tx_disable, irq_en, wr_valid;
  logic [WW-1:0] wr_data;
  logic wr_ready, bclk, fsync, sdata, underrun, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  codec_frame_tx #(
    .CLK_DIV(4), .FRAME_BITS(FB), .WORD_W(WW), .WORDS_PER_FRAME(3),
    .FIFO_DEPTH(16), .ALARM_WORDS(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_disable(tx_disable),
    .irq_en(irq_en), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .bclk(bclk), .fsync(fsync), .sdata(sdata), .underrun(underrun), .irq(irq)
  );

  // Receiver model: capture on each falling edge of bclk.
  bit prev_bclk = 1'b0;
  int nbits = 0;
  bit bitlog [0:4095];
  bit fslog  [0:4095];
  always @(negedge clk) begin
    if (prev_bclk && !bclk) begin
      if (nbits < 4096) begin
        bitlog[nbits] = sdata;
        fslog[nbits]  = fsync;
      end
      nbits++;
    end
    prev_bclk = bclk;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_enable();
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); tx_enable = 1'b0;
  endtask

  task automatic pulse_disable();
    @(negedge clk); tx_disable = 1'b1;
    @(negedge clk); tx_disable = 1'b0;
  endtask

  task automatic try_push(input logic [WW-1:0] w, output bit taken);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = w;
    taken = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_bits(input int n);
    while (nbits < n) @(negedge clk);
  endtask

  function automatic int next_fs(input int from);
    for (int i = from; i < 4096; i++) if (fslog[i]) return i;
    return -1;
  endfunction

  task automatic check_frame(input int base, input logic [WW-1:0] a,
                             input logic [WW-1:0] b, input logic [WW-1:0] c,
                             input string tag);
    logic [63:0] dat = '0;
    logic [63:0] fs  = '0;
    for (int i = 0; i < FB; i++) begin
      dat[i] = bitlog[base+i];
      fs[i]  = fslog[base+i];
    end
    check(fs == 64'h1, {tag, " R3 fsync"}, fs, 64'h1);
    check(dat == {16'h0, c, b, a}, {tag, " R4 R5 data"}, dat, {16'h0, c, b, a});
  endtask

  task automatic t_reset();
    check(!bclk && !fsync && !sdata, "R1 outputs idle",
          {61'd0, bclk, fsync, sdata}, 64'd0);
    check(!underrun && wr_ready, "R1 flags", {62'd0, underrun, wr_ready}, 64'd1);
    check(irq == 1'b1, "R1 R9 empty fifo irq", irq, 1);
  endtask

  task automatic t_basic_frame();
    bit tk;
    try_push(16'h8001, tk);
    try_push(16'h3C5A, tk);
    try_push(16'hF00D, tk);
    check(irq == 1'b1, "R9 three queued", irq, 1);
    nbits = 0;
    pulse_enable();
    wait_bits(2*FB);
    check(next_fs(0) == 0, "R4 first bit with fsync", next_fs(0), 0);
    check_frame(0, 16'h8001, 16'h3C5A, 16'hF00D, "basic f0");
    check_frame(FB, 16'h0, 16'h0, 16'h0, "basic f1 R8");
    check(underrun == 1'b1, "R8 underrun set", underrun, 1);
  endtask

  task automatic t_bit_clock();
    int hi = 0, lo = 0, moves = 0;
    bit pb, ps, pf;
    @(negedge clk);
    while (!(bclk && !pb)) begin pb = bclk; @(negedge clk); end
    while (bclk)  begin hi++; @(negedge clk); end
    while (!bclk) begin lo++; @(negedge clk); end
    check(hi == 2 && lo == 2, "R2 bclk shape", {hi[31:0], lo[31:0]}, {32'd2, 32'd2});
    pb = bclk; ps = sdata; pf = fsync;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ((sdata != ps || fsync != pf) && !(bclk && !pb)) moves++;
      pb = bclk; ps = sdata; pf = fsync;
    end
    check(moves == 0, "R6 change only at bclk rise", moves, 0);
  endtask

  task automatic t_disable();
    int bad = 0;
    @(negedge clk); tx_disable = 1'b1;
    @(negedge clk); tx_disable = 1'b0;
    check(!bclk && !fsync && !sdata, "R10 low after stop",
          {61'd0, bclk, fsync, sdata}, 64'd0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bclk || fsync || sdata) bad++;
    end
    check(bad == 0, "R10 stays low", bad, 0);
    check(underrun == 1'b1, "R8 sticky while stopped", underrun, 1);
  endtask

  task automatic t_fill_and_drain();
    bit tk;
    logic [WW-1:0] w [16];
    int base;
    for (int i = 0; i < 16; i++) begin
      w[i] = {4'hC, i[3:0], 4'h3 ^ i[3:0], 4'hA};
      try_push(w[i], tk);
    end
    check(wr_ready == 1'b0, "R7 full drops ready", wr_ready, 0);
    check(irq == 1'b0, "R9 above alarm", irq, 0);
    try_push(16'hDEAD, tk);
    check(tk == 1'b0, "R7 word refused when full", tk, 0);
    nbits = 0;
    pulse_enable();
    check(underrun == 1'b0, "R8 cleared by start", underrun, 1'b0);
    wait_bits(6*FB);
    for (int f = 0; f < 5; f++) begin
      base = f*FB;
      check_frame(base, w[3*f], w[3*f+1], w[3*f+2], $sformatf("fill f%0d", f));
    end
    check_frame(5*FB, w[15], 16'h0, 16'h0, "fill f5 R7 R8");
    check(irq == 1'b1, "R9 drained", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R9 masked", irq, 0);
    irq_en = 1'b1;
  endtask

  task automatic t_restart_ignored();
    int n0, f1;
    logic [63:0] pat, exp;
    n0 = nbits;
    wait_bits(n0 + 20);
    pulse_enable();
    wait_bits(n0 + 3*FB + 60);
    f1 = next_fs(n0);
    pat = '0; exp = '0;
    for (int i = 0; i < 60; i++) begin
      pat[i] = fslog[f1 + 52 - 4 + i];
      exp[i] = ((52 - 4 + i) % FB == 0);
    end
    check(pat == exp, "R11 frame timing unchanged", pat, exp);
    pulse_disable();
  endtask

  initial begin
    rst_n = 1'b0; tx_enable = 1'b0; tx_disable = 1'b0; irq_en = 1'b1;
    wr_valid = 1'b0; wr_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_frame();
    t_bit_clock();
    t_disable();
    t_fill_and_drain();
    t_restart_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule